// File: doc/BRIEF.md
# Serial EEPROM Bus Slave

This block is a two-wire serial bus slave (I2C-style SCL/SDA) in front of a byte-wide storage array of 512 locations. A master addresses the device with an address byte that carries a fixed three-bit prefix and the state of three strap pins, so eight of these devices can share one bus. The master then moves data through single-byte writes, page writes of up to eight bytes, random reads and sequential reads. The storage array is modelled as a register array. The open-drain data line is split into an input, a constant-low output and an output enable, and the clock is oversampled by the block's own system clock.

Written bytes are first collected in an eight-slot page buffer. A STOP commits the buffer to the array in one step and starts a self-timed write cycle. That cycle counts either system clocks or rising edges of an external tick input. While it runs, the device leaves its own address unanswered, so a master can poll for completion. In sequential reads an internal address counter walks across the whole array and wraps from the top location to location zero.

Top module: `serialNvmSlave`

## Requirements
- R1: After reset the block is idle with the SDA output enable low, no write cycle running, and it acknowledges its own address.
- R2: An address byte is acknowledged only when bits 7:5 equal 3'b101 and bits 4:2 equal the strap inputs. Bit 0 selects the direction (0 = write, 1 = read). Any other address byte gets no acknowledge.
- R3: A write of one data byte stores that byte at the addressed location.
- R4: A write of two to eight data bytes stores them at consecutive locations, and all of them are committed by the single STOP that ends the transfer.
- R5: Data bytes in a write stay inside the aligned 8-byte page that holds the start address, wrapping the low three address bits. When more than eight bytes are sent, later bytes overwrite earlier ones in the same page.
- R6: Bit 1 of a write-direction address byte becomes word-address bit 8, and the following byte supplies word-address bits 7:0.
- R7: A word address set in a write-direction phase, followed by a repeated START and a read-direction address byte, returns the byte stored at that word address.
- R8: During a read, each byte acknowledged by the master is followed by the byte at the next location. The counter wraps from location 511 to location 0.
- R9: From the STOP that commits a write, the device gives no acknowledge to its own address for EW_CYCLES system clocks, and it acknowledges again afterwards.
- R10: A STOP after a write-direction transfer with no data bytes starts no write cycle and leaves the array unchanged.
- R11: With the external timing select high, the write cycle lasts until EXT_TICKS rising edges of the external tick input have been seen, however many system clocks pass.
- R12: A master NACK after a read byte, followed by STOP, ends the read with SDA released (output enable low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset (power-on reset) |
| sclIn | input | 1 | Serial clock line from the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| sdaOut | output | 1 | Data value driven when enabled (always 0, open-drain) |
| sdaOe | output | 1 | High pulls the data line low |
| strap | input | 3 | Device select straps compared with address bits 4:2 |
| ewExtSel | input | 1 | High: write cycle timed by ewTick edges instead of clocks |
| ewTick | input | 1 | External timing input for the write cycle |

## Verification
Two functions can land in the same cycle: the write cycle started by a STOP, and a device-address decision that has to consult that cycle's busy state. The bench provokes this by polling its own address straight after a committing STOP. It expects no acknowledge, then an acknowledge once the cycle length has passed. In external-tick mode it does the same with the last tick given just before the poll, after first checking that one tick short of the count still gives no acknowledge. The page-wrap and 511-to-0 read wrap are judged by reading back every byte of the affected page and the bytes on either side of the wrap.

// File: rtl/nvmPkg.sv
package nvmPkg;
  localparam int MEM_DEPTH = 512;
  localparam int ADDR_W    = 9;
  localparam int PAGE_LEN  = 8;
  localparam int PAGE_W    = $clog2(PAGE_LEN);

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK, S_TX, S_MACK
  } busState_e;

  typedef enum logic [1:0] {
    C_DEV, C_WORD, C_DATA
  } byteCtx_e;

  // one-cycle strobes from bus control to storage datapath
  typedef struct packed {
    logic       start;
    logic       stop;
    logic       devHit;
    logic       wordLoad;
    logic       dataPush;
    logic       readAdvance;
    logic [7:0] rxByte;
  } busStrobe_t;
endpackage

// File: rtl/nvmBusCtrl.sv
module nvmBusCtrl
  import nvmPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strap,
  input  logic       busyIn,
  input  logic [7:0] rdData,
  output logic       sdaOe,
  output busStrobe_t stb
);
  logic [2:0] sclQ, sdaQ;
  logic       sclS, sclP, sdaS, sdaP;
  logic       sclRise, sclFall, startDet, stopDet;

  busState_e  state;
  byteCtx_e   ctx;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg, txReg;
  logic       readMode, mAck;
  logic       devMatch;

  assign sclS = sclQ[1];
  assign sclP = sclQ[2];
  assign sdaS = sdaQ[1];
  assign sdaP = sdaQ[2];
  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;
  assign devMatch = (shiftReg[7:5] == 3'b101) && (shiftReg[4:2] == strap);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= '1;
      sdaQ <= '1;
    end else begin
      sclQ <= {sclQ[1:0], sclIn};
      sdaQ <= {sdaQ[1:0], sdaIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      ctx      <= C_DEV;
      bitCnt   <= '0;
      shiftReg <= '0;
      txReg    <= '0;
      readMode <= 1'b0;
      mAck     <= 1'b0;
      sdaOe    <= 1'b0;
      stb      <= '0;
    end else begin
      stb <= '0;
      if (startDet) begin
        state     <= S_RX;
        ctx       <= C_DEV;
        bitCnt    <= '0;
        sdaOe     <= 1'b0;
        stb.start <= 1'b1;
      end else if (stopDet) begin
        state    <= S_IDLE;
        sdaOe    <= 1'b0;
        stb.stop <= 1'b1;
      end else begin
        case (state)
          S_RX: begin
            if (sclRise && bitCnt != 4'd8) begin
              shiftReg <= {shiftReg[6:0], sdaS};
              bitCnt   <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              stb.rxByte <= shiftReg;
              case (ctx)
                C_DEV: begin
                  if (devMatch && !busyIn) begin
                    sdaOe      <= 1'b1;
                    state      <= S_ACK;
                    readMode   <= shiftReg[0];
                    ctx        <= C_WORD;
                    stb.devHit <= 1'b1;
                  end else begin
                    state <= S_IDLE;
                  end
                end
                C_WORD: begin
                  sdaOe        <= 1'b1;
                  state        <= S_ACK;
                  ctx          <= C_DATA;
                  stb.wordLoad <= 1'b1;
                end
                default: begin
                  sdaOe        <= 1'b1;
                  state        <= S_ACK;
                  stb.dataPush <= 1'b1;
                end
              endcase
            end
          end
          S_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (readMode) begin
                state <= S_TX;
                txReg <= rdData;
                sdaOe <= ~rdData[7];
              end else begin
                state <= S_RX;
                sdaOe <= 1'b0;
              end
            end
          end
          S_TX: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall) begin
              if (bitCnt == 4'd8) begin
                state <= S_MACK;
                sdaOe <= 1'b0;
              end else begin
                txReg <= {txReg[6:0], 1'b0};
                sdaOe <= ~txReg[6];
              end
            end
          end
          S_MACK: begin
            if (sclRise) begin
              mAck            <= ~sdaS;
              stb.readAdvance <= 1'b1;
            end else if (sclFall) begin
              if (mAck) begin
                state  <= S_TX;
                bitCnt <= '0;
                txReg  <= rdData;
                sdaOe  <= ~rdData[7];
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R12: no drive on SDA while the controller rests in idle
  p_release_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && $past(state) == S_IDLE) |-> !sdaOe);

  // R9: an address acknowledge is never started while a write cycle runs
  p_nack_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ACK && ctx == C_WORD && $past(state) != S_ACK) |-> !$past(busyIn));

  // R2: acknowledge of an address byte only follows a full 8-bit shift
  p_ack_after_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ACK && $past(state) == S_RX) |-> $past(bitCnt) == 4'd8);
endmodule

// File: rtl/nvmStore.sv
module nvmStore
  import nvmPkg::*;
#(
  parameter int EW_CYCLES = 5000,
  parameter int EXT_TICKS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  busStrobe_t stb,
  input  logic       ewExtSel,
  input  logic       ewTick,
  output logic       busy,
  output logic [7:0] rdData
);
  localparam int TMR_MAX = (EW_CYCLES > EXT_TICKS) ? EW_CYCLES : EXT_TICKS;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  logic [7:0]        mem [MEM_DEPTH];
  logic [7:0]        pageBuf [PAGE_LEN];
  logic [PAGE_LEN-1:0] slotValid;
  logic [ADDR_W-1:0] addr;
  logic              hiBit;
  logic [TMR_W-1:0]  tmr;
  logic [2:0]        tickQ;
  logic              tickRise, anyValid, commit;

  assign tickRise = tickQ[1] & ~tickQ[2];
  assign anyValid = |slotValid;
  assign commit   = stb.stop && anyValid;
  assign busy     = (tmr != '0);
  assign rdData   = mem[addr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr      <= '0;
      hiBit     <= 1'b0;
      slotValid <= '0;
      tmr       <= '0;
      tickQ     <= '0;
      for (int i = 0; i < PAGE_LEN; i++) pageBuf[i] <= '0;
    end else begin
      tickQ <= {tickQ[1:0], ewTick};
      if (stb.start) slotValid <= '0;
      if (stb.devHit && !stb.rxByte[0]) hiBit <= stb.rxByte[1];
      if (stb.wordLoad) begin
        addr      <= {hiBit, stb.rxByte};
        slotValid <= '0;
      end
      if (stb.dataPush) begin
        pageBuf[addr[PAGE_W-1:0]]   <= stb.rxByte;
        slotValid[addr[PAGE_W-1:0]] <= 1'b1;
        addr[PAGE_W-1:0]            <= addr[PAGE_W-1:0] + 1'b1;
      end
      if (stb.readAdvance)
        addr <= (addr == ADDR_W'(MEM_DEPTH - 1)) ? '0 : addr + 1'b1;
      if (commit) begin
        slotValid <= '0;
        tmr       <= ewExtSel ? TMR_W'(EXT_TICKS) : TMR_W'(EW_CYCLES);
      end else if (busy && (!ewExtSel || tickRise)) begin
        tmr <= tmr - 1'b1;
      end
    end
  end

  // array: nonvolatile contents, not cleared by reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_LEN; i++)
      if (commit && slotValid[i])
        mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pageBuf[i];
  end

  // R4: a committing STOP always starts the timed cycle
  p_busy_on_commit_r4: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> busy);

  // R5: data bytes never move the address out of its page
  p_page_stay_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.dataPush |=> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));

  // R8: read counter wraps from the top location to zero
  p_seq_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.readAdvance && addr == ADDR_W'(MEM_DEPTH - 1)) |=> addr == '0);

  // R10: a STOP with nothing buffered starts no cycle
  p_empty_stop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stop && !anyValid && !busy) |=> !busy);

  // R11: in external mode the cycle only shortens on a tick edge
  p_ext_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ewExtSel && !tickRise) |=> busy);
endmodule

// File: rtl/serialNvmSlave.sv
module serialNvmSlave
  import nvmPkg::*;
#(
  parameter int EW_CYCLES = 5000,
  parameter int EXT_TICKS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOut,
  output logic       sdaOe,
  input  logic [2:0] strap,
  input  logic       ewExtSel,
  input  logic       ewTick
);
  busStrobe_t stb;
  logic       busy;
  logic [7:0] rdData;

  assign sdaOut = 1'b0;

  nvmBusCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .strap  (strap),
    .busyIn (busy),
    .rdData (rdData),
    .sdaOe  (sdaOe),
    .stb    (stb)
  );

  nvmStore #(.EW_CYCLES(EW_CYCLES), .EXT_TICKS(EXT_TICKS)) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .ewExtSel (ewExtSel),
    .ewTick   (ewTick),
    .busy     (busy),
    .rdData   (rdData)
  );
endmodule

// File: tb/serialNvmSlave_tb.sv
module serialNvmSlave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;
  localparam int EW         = 600;
  localparam int XT         = 4;
  localparam logic [2:0] STRAP = 3'b101;

  typedef struct packed {
    logic [8:0] addr;
    logic [7:0] data;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{addr: 9'h000, data: 8'h3C},
    '{addr: 9'h1FF, data: 8'hA5},
    '{addr: 9'h100, data: 8'h5A},
    '{addr: 9'h0FF, data: 8'hC3},
    '{addr: 9'h010, data: 8'h01},
    '{addr: 9'h1F0, data: 8'h7E}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSdaLow = 1'b0;
  logic ewExtSel = 1'b0;
  logic ewTick = 1'b0;
  logic sdaOut, sdaOe, sdaLine;
  int   total = 0;
  int   bad = 0;
  logic [7:0] pageData [16];
  logic [7:0] rdBuf [16];

  assign sdaLine = !(mSdaLow || sdaOe);

  always #(CLK_PERIOD/2) clk = ~clk;

  serialNvmSlave #(.EW_CYCLES(EW), .EXT_TICKS(XT)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .sdaOut(sdaOut), .sdaOe(sdaOe), .strap(STRAP),
    .ewExtSel(ewExtSel), .ewTick(ewTick)
  );

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mSdaLow = 1'b0; wq(); scl = 1'b1; wq(); mSdaLow = 1'b1; wq(); scl = 1'b0; wq();
  endtask

  task automatic busStop();
    mSdaLow = 1'b1; wq(); scl = 1'b1; wq(); mSdaLow = 1'b0; wq();
  endtask

  task automatic sendBit(logic b);
    mSdaLow = !b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic recvBit(output logic b);
    mSdaLow = 1'b0; wq(); scl = 1'b1; wq(); b = sdaLine; wq(); scl = 1'b0; wq();
  endtask

  task automatic sendByte(logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(b);
    ack = !b;
  endtask

  task automatic recvByte(logic giveAck, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) recvBit(v[i]);
    sendBit(!giveAck);
  endtask

  function automatic logic [7:0] devByte(logic [2:0] s, logic a8, logic rd);
    return {3'b101, s, a8, rd};
  endfunction

  task automatic pageWrite(logic [8:0] a, int n);
    logic ack;
    busStart();
    sendByte(devByte(STRAP, a[8], 1'b0), ack);
    sendByte(a[7:0], ack);
    for (int i = 0; i < n; i++) sendByte(pageData[i], ack);
    busStop();
  endtask

  task automatic seqRead(logic [8:0] a, int n);
    logic ack;
    busStart();
    sendByte(devByte(STRAP, a[8], 1'b0), ack);
    sendByte(a[7:0], ack);
    busStart();
    sendByte(devByte(STRAP, 1'b0, 1'b1), ack);
    for (int i = 0; i < n; i++) recvByte(i < n - 1, rdBuf[i]);
    busStop();
  endtask

  task automatic poll(output logic ack);
    busStart();
    sendByte(devByte(STRAP, 1'b0, 1'b0), ack);
    busStop();
  endtask

  task automatic tick();
    ewTick = 1'b1; repeat (4) @(negedge clk);
    ewTick = 1'b0; repeat (4) @(negedge clk);
  endtask

  initial begin
    logic ack;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1 oe low after reset", {7'd0, sdaOe}, 8'd0);
    poll(ack);
    chk("R1 own address acked after reset", {7'd0, ack}, 8'd1);

    // R2: foreign straps and foreign prefix are ignored
    busStart(); sendByte(devByte(~STRAP, 1'b0, 1'b0), ack); busStop();
    chk("R2 wrong strap nacked", {7'd0, ack}, 8'd0);
    busStart(); sendByte({3'b011, STRAP, 2'b00}, ack); busStop();
    chk("R2 wrong prefix nacked", {7'd0, ack}, 8'd0);

    // R3 R6 R7: table of single-byte writes, then random reads
    foreach (VECS[k]) begin
      pageData[0] = VECS[k].data;
      pageWrite(VECS[k].addr, 1);
      repeat (EW + 20) @(negedge clk);
    end
    foreach (VECS[k]) begin
      seqRead(VECS[k].addr, 1);
      chk($sformatf("R3 R6 R7 byte at %h", VECS[k].addr), rdBuf[0], VECS[k].data);
    end

    // R4 R9: full page write, poll during and after the cycle
    for (int i = 0; i < 8; i++) pageData[i] = 8'h40 + 8'(i);
    pageWrite(9'h048, 8);
    poll(ack);
    chk("R9 nack right after commit", {7'd0, ack}, 8'd0);
    repeat (EW) @(negedge clk);
    poll(ack);
    chk("R9 ack after cycle", {7'd0, ack}, 8'd1);
    seqRead(9'h048, 8);
    for (int i = 0; i < 8; i++)
      chk("R4 R8 page byte", rdBuf[i], 8'h40 + 8'(i));

    // R5: ten bytes from offset 6 wrap inside page 0x0E0
    for (int i = 0; i < 10; i++) pageData[i] = 8'hB0 + 8'(i);
    pageWrite(9'h0E6, 10);
    repeat (EW + 20) @(negedge clk);
    seqRead(9'h0E0, 8);
    for (int k = 0; k < 6; k++) chk("R5 wrapped byte", rdBuf[k], 8'hB2 + 8'(k));
    chk("R5 overwritten offset 6", rdBuf[6], 8'hB8);
    chk("R5 overwritten offset 7", rdBuf[7], 8'hB9);

    // R8: sequential read across top of array
    seqRead(9'h1FF, 2);
    chk("R8 top location", rdBuf[0], 8'hA5);
    chk("R8 wrap to zero", rdBuf[1], 8'h3C);

    // R12: after NACK and STOP the line is released
    chk("R12 oe low after read", {7'd0, sdaOe}, 8'd0);
    chk("R12 line high after read", {7'd0, sdaLine}, 8'd1);

    // R10: address-only write starts no cycle and changes nothing
    busStart();
    sendByte(devByte(STRAP, 1'b0, 1'b0), ack);
    sendByte(8'h10, ack);
    busStop();
    poll(ack);
    chk("R10 no cycle after empty write", {7'd0, ack}, 8'd1);
    seqRead(9'h010, 1);
    chk("R10 array unchanged", rdBuf[0], 8'h01);

    // R11: external tick timing
    ewExtSel = 1'b1;
    pageData[0] = 8'h99;
    pageWrite(9'h020, 1);
    repeat (2 * EW) @(negedge clk);
    poll(ack);
    chk("R11 still busy without ticks", {7'd0, ack}, 8'd0);
    for (int i = 0; i < XT - 1; i++) tick();
    poll(ack);
    chk("R11 busy one tick short", {7'd0, ack}, 8'd0);
    tick();
    poll(ack);
    chk("R11 ready after last tick", {7'd0, ack}, 8'd1);
    ewExtSel = 1'b0;
    seqRead(9'h020, 1);
    chk("R11 R3 data written", rdBuf[0], 8'h99);

    summary();
    $finish;
  end
endmodule